// File: doc/BRIEF.md
# Programmable Startup Phase Sequencer

Once the configuration data is loaded and a start command arrives, this block runs a device through the final stage of bring-up. It walks a phase counter from 0 to 7 and makes three global changes along the way. It enables global writes so that memories and flip-flops may change state. It lifts the global tristate so that the I/O becomes active. It drives the done output high. Each of these changes happens in a phase chosen by configuration. Optional holds can keep the counter in a chosen phase until the clock managers report lock or until I/O impedance calibration reports a match. End-of-startup is always raised in phase 7.

The counter sits in phase 0 (state `ST_IDLE`) until `start_i` is seen while `loaded_i` is high. It then moves to phase 1 (`ST_STEP`). In phases 1 to 6, each cycle either advances one phase (`ST_STEP`) or, while an enabled hold is unmet, stays where it is (`ST_HOLD`). From phase 6 with no hold it enters phase 7 (`ST_EOS`) and stays there until reset. The named transitions are: start (`ST_IDLE` to `ST_STEP`), stall (to `ST_HOLD`), resume (`ST_HOLD` to `ST_STEP`) and finish (to `ST_EOS`). Every event output is sticky.

Top module: `startup_seq`

## Requirements
- R1: While `rst_n` is low, the outputs are `phase_o`=0, `gwe_o`=0, `gts_o`=1, `done_o`=0 and `eos_o`=0.
- R2: In phase 0 the sequencer moves to phase 1 on the clock edge that samples `start_i`=1 together with `loaded_i`=1. `start_i` has no effect when `loaded_i` is 0, and it has no effect once the sequence has left phase 0.
- R3: `phase_o` changes by at most +1 per clock. With no hold active it counts 1, 2, … 7 on consecutive cycles.
- R4: A phase selection of 1 to 6 is used as given. A selection of 0 or 7 is treated as 6. This applies to all five 3-bit selection inputs.
- R5: `gwe_o` rises, `gts_o` falls and `done_o` rises in the first cycle in which `phase_o` equals the effective selection for that event. Several events may share one phase.
- R6: Once changed, `gwe_o`, `gts_o` and `done_o` keep their new values until reset, whatever the status inputs do.
- R7: When `wait_lock_en_i`=1, `phase_o` equals the effective `sel_lock_i`, and `lock_i`=0, the phase does not change on the next clock.
- R8: When `wait_match_en_i`=1, `phase_o` equals the effective `sel_match_i`, and `match_i`=0, the phase does not change on the next clock. When both holds are placed in one phase, the counter advances only once both status inputs are high.
- R9: `eos_o` is high exactly when `phase_o`=7. Phase 7 is kept until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command strobe |
| loaded_i | input | 1 | Configuration frames have been loaded |
| lock_i | input | 1 | Clock managers locked |
| match_i | input | 1 | Impedance calibration matched |
| wait_lock_en_i | input | 1 | Enable the lock hold |
| wait_match_en_i | input | 1 | Enable the match hold |
| sel_gwe_i | input | 3 | Phase for write enable |
| sel_gts_i | input | 3 | Phase for tristate release |
| sel_done_i | input | 3 | Phase for done release |
| sel_lock_i | input | 3 | Phase of the lock hold |
| sel_match_i | input | 3 | Phase of the match hold |
| phase_o | output | 3 | Current phase |
| gwe_o | output | 1 | Global write enable |
| gts_o | output | 1 | Global tristate, high = I/O held off |
| done_o | output | 1 | Done |
| eos_o | output | 1 | End of startup |

## Verification
An event firing and a hold can land in the same phase. The event must still fire on entry to that phase, while the counter stays there for as long as the hold lasts. One scenario places write enable, the lock hold and the match hold all in phase 3. It raises `lock_i` a few cycles before `match_i`. The bench expects `gwe_o` high from the first phase-3 cycle and expects phase 4 only on the clock after both status inputs are high. A second scenario sets several events to clamped selections so that they fire together in phase 6.

// File: rtl/startup_pkg.sv
package startup_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STEP,
        ST_HOLD,
        ST_EOS
    } seq_state_t;

    // index of each phase selection in the normalised selection array
    localparam int SEL_GWE   = 0;
    localparam int SEL_GTS   = 1;
    localparam int SEL_DONE  = 2;
    localparam int SEL_LOCK  = 3;
    localparam int SEL_MATCH = 4;
    localparam int NUM_SEL   = 5;
    localparam int NUM_EVT   = 3;

endpackage

// File: rtl/startup_sel_norm.sv
module startup_sel_norm #(
    parameter int NUM_PHASES = 8,
    localparam int PW = $clog2(NUM_PHASES)
) (
    input  logic [PW-1:0] sel_i,
    output logic [PW-1:0] sel_o
);
    localparam int LAST = NUM_PHASES - 1;

    // selections outside the programmable range fold onto the last programmable phase
    always_comb begin
        if (sel_i == '0 || sel_i == PW'(LAST)) begin
            sel_o = PW'(LAST - 1);
        end else begin
            sel_o = sel_i;
        end
    end
endmodule

// File: rtl/startup_hold_eval.sv
module startup_hold_eval #(
    parameter int NUM_PHASES = 8,
    localparam int PW = $clog2(NUM_PHASES)
) (
    input  logic [PW-1:0] phase_i,
    input  logic          lock_en_i,
    input  logic [PW-1:0] lock_phase_i,
    input  logic          lock_i,
    input  logic          match_en_i,
    input  logic [PW-1:0] match_phase_i,
    input  logic          match_i,
    output logic          hold_o
);
    logic lock_block;
    logic match_block;

    always_comb begin
        lock_block  = lock_en_i  && (phase_i == lock_phase_i)  && !lock_i;
        match_block = match_en_i && (phase_i == match_phase_i) && !match_i;
        hold_o      = lock_block || match_block;
    end
endmodule

// File: rtl/startup_evt_flag.sv
module startup_evt_flag #(
    parameter int NUM_PHASES = 8,
    localparam int PW = $clog2(NUM_PHASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    input  logic [PW-1:0] next_phase_i,
    input  logic [PW-1:0] fire_phase_i,
    output logic          flag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (adv_i && (next_phase_i == fire_phase_i)) begin
            flag_o <= 1'b1;
        end
    end
endmodule

// File: rtl/startup_seq.sv
module startup_seq
    import startup_pkg::*;
#(
    parameter int NUM_PHASES = 8,
    localparam int PW = $clog2(NUM_PHASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          loaded_i,
    input  logic          lock_i,
    input  logic          match_i,
    input  logic          wait_lock_en_i,
    input  logic          wait_match_en_i,
    input  logic [PW-1:0] sel_gwe_i,
    input  logic [PW-1:0] sel_gts_i,
    input  logic [PW-1:0] sel_done_i,
    input  logic [PW-1:0] sel_lock_i,
    input  logic [PW-1:0] sel_match_i,
    output logic [PW-1:0] phase_o,
    output logic          gwe_o,
    output logic          gts_o,
    output logic          done_o,
    output logic          eos_o
);
    localparam int LAST     = NUM_PHASES - 1;
    localparam int LAST_PRG = NUM_PHASES - 2;

    seq_state_t    state_q, state_d;
    logic [PW-1:0] phase_q, phase_d;
    logic          hold;
    logic          adv;
    logic          eos_q;
    logic [PW-1:0] sel_raw [NUM_SEL];
    logic [PW-1:0] sel_nrm [NUM_SEL];
    logic [NUM_EVT-1:0] evt_flag;

    always_comb begin
        sel_raw[SEL_GWE]   = sel_gwe_i;
        sel_raw[SEL_GTS]   = sel_gts_i;
        sel_raw[SEL_DONE]  = sel_done_i;
        sel_raw[SEL_LOCK]  = sel_lock_i;
        sel_raw[SEL_MATCH] = sel_match_i;
    end

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_norm
        startup_sel_norm #(.NUM_PHASES(NUM_PHASES)) u_norm (
            .sel_i (sel_raw[g]),
            .sel_o (sel_nrm[g])
        );
    end

    startup_hold_eval #(.NUM_PHASES(NUM_PHASES)) u_hold (
        .phase_i       (phase_q),
        .lock_en_i     (wait_lock_en_i),
        .lock_phase_i  (sel_nrm[SEL_LOCK]),
        .lock_i        (lock_i),
        .match_en_i    (wait_match_en_i),
        .match_phase_i (sel_nrm[SEL_MATCH]),
        .match_i       (match_i),
        .hold_o        (hold)
    );

    // next state and next phase
    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i && loaded_i) begin
                    state_d = ST_STEP;
                    phase_d = PW'(1);
                end
            end
            ST_STEP, ST_HOLD: begin
                if (hold) begin
                    state_d = ST_HOLD;
                end else if (phase_q == PW'(LAST_PRG)) begin
                    state_d = ST_EOS;
                    phase_d = PW'(LAST);
                end else begin
                    state_d = ST_STEP;
                    phase_d = phase_q + PW'(1);
                end
            end
            ST_EOS: begin
                state_d = ST_EOS;
            end
        endcase
    end

    assign adv = (phase_d != phase_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eos_q <= 1'b0;
        end else begin
            eos_q <= (state_d == ST_EOS);
        end
    end

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
        startup_evt_flag #(.NUM_PHASES(NUM_PHASES)) u_flag (
            .clk          (clk),
            .rst_n        (rst_n),
            .adv_i        (adv),
            .next_phase_i (phase_d),
            .fire_phase_i (sel_nrm[e]),
            .flag_o       (evt_flag[e])
        );
    end

    assign phase_o = phase_q;
    assign gwe_o   = evt_flag[SEL_GWE];
    assign gts_o   = ~evt_flag[SEL_GTS];
    assign done_o  = evt_flag[SEL_DONE];
    assign eos_o   = eos_q;
endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk #(
    parameter int NUM_PHASES = 8,
    localparam int PW = $clog2(NUM_PHASES)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          loaded_i,
    input logic          lock_i,
    input logic          match_i,
    input logic          wait_lock_en_i,
    input logic          wait_match_en_i,
    input logic [PW-1:0] sel_gwe_i,
    input logic [PW-1:0] sel_gts_i,
    input logic [PW-1:0] sel_done_i,
    input logic [PW-1:0] sel_lock_i,
    input logic [PW-1:0] sel_match_i,
    input logic [PW-1:0] phase_o,
    input logic          gwe_o,
    input logic          gts_o,
    input logic          done_o,
    input logic          eos_o
);
    localparam int LAST = NUM_PHASES - 1;

    function automatic logic [PW-1:0] eff(input logic [PW-1:0] s);
        if (s == '0 || s == PW'(LAST)) return PW'(LAST - 1);
        return s;
    endfunction

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_state_chk: assert (phase_o == '0 && !gwe_o && gts_o && !done_o && !eos_o);
        end
    end

    // R2
    idle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == '0 && !(start_i && loaded_i)) |=> phase_o == '0);

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (phase_o == $past(phase_o) || phase_o == $past(phase_o) + PW'(1)));

    // R5
    gwe_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == eff(sel_gwe_i)) |-> gwe_o);

    // R5
    gts_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == eff(sel_gts_i)) |-> !gts_o);

    // R5
    done_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == eff(sel_done_i)) |-> done_o);

    // R6
    gwe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gwe_o |=> gwe_o);

    // R6
    gts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gts_o |=> !gts_o);

    // R6
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);

    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_lock_en_i && phase_o == eff(sel_lock_i) && !lock_i) |=> $stable(phase_o));

    // R8
    match_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_match_en_i && phase_o == eff(sel_match_i) && !match_i) |=> $stable(phase_o));

    // R9
    eos_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eos_o == (phase_o == PW'(LAST)));

    // R9
    eos_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eos_o |=> (eos_o && phase_o == PW'(LAST)));
endmodule

bind startup_seq startup_seq_chk #(.NUM_PHASES(NUM_PHASES)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .loaded_i        (loaded_i),
    .lock_i          (lock_i),
    .match_i         (match_i),
    .wait_lock_en_i  (wait_lock_en_i),
    .wait_match_en_i (wait_match_en_i),
    .sel_gwe_i       (sel_gwe_i),
    .sel_gts_i       (sel_gts_i),
    .sel_done_i      (sel_done_i),
    .sel_lock_i      (sel_lock_i),
    .sel_match_i     (sel_match_i),
    .phase_o         (phase_o),
    .gwe_o           (gwe_o),
    .gts_o           (gts_o),
    .done_o          (done_o),
    .eos_o           (eos_o)
);

// File: tb/test_startup_seq.sv
module test_startup_seq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, loaded_i = 1'b0, lock_i = 1'b0, match_i = 1'b0;
    logic       wait_lock_en_i = 1'b0, wait_match_en_i = 1'b0;
    logic [2:0] sel_gwe_i = 3'd1, sel_gts_i = 3'd1, sel_done_i = 3'd1;
    logic [2:0] sel_lock_i = 3'd1, sel_match_i = 3'd1;
    logic [2:0] phase_o;
    logic       gwe_o, gts_o, done_o, eos_o;

    typedef struct {
        int    ph;
        bit    gwe;
        bit    gts;
        bit    done;
        bit    eos;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int   checks = 0;
    int   errors = 0;

    int m_ph;
    bit m_gwe, m_gts, m_done, m_eos;

    always #(CLK_PERIOD / 2) clk = ~clk;

    startup_seq i_startup_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .loaded_i(loaded_i),
        .lock_i(lock_i), .match_i(match_i),
        .wait_lock_en_i(wait_lock_en_i), .wait_match_en_i(wait_match_en_i),
        .sel_gwe_i(sel_gwe_i), .sel_gts_i(sel_gts_i), .sel_done_i(sel_done_i),
        .sel_lock_i(sel_lock_i), .sel_match_i(sel_match_i),
        .phase_o(phase_o), .gwe_o(gwe_o), .gts_o(gts_o), .done_o(done_o), .eos_o(eos_o)
    );

    // R4: 0 and 7 are treated as 6
    function automatic int eff(input int s);
        return (s == 0 || s == 7) ? 6 : s;
    endfunction

    function automatic void push_exp(input string tag);
        exp_t e;
        e.ph = m_ph; e.gwe = m_gwe; e.gts = m_gts; e.done = m_done; e.eos = m_eos;
        e.tag = tag;
        sb_q.push_back(e);
    endfunction

    // R1: reset cycle with expected reset values
    task automatic reset_cycle();
        @(negedge clk);
        rst_n = 1'b0;
        start_i = 1'b0; loaded_i = 1'b0; lock_i = 1'b0; match_i = 1'b0;
        m_ph = 0; m_gwe = 0; m_gts = 1; m_done = 0; m_eos = 0;
        push_exp("R1");
    endtask

    task automatic cyc(input bit st, input bit ld, input bit lk, input bit mt, input string tag);
        bit hold;
        @(negedge clk);
        rst_n = 1'b1;
        start_i = st; loaded_i = ld; lock_i = lk; match_i = mt;
        if (m_ph == 0) begin
            if (st && ld) m_ph = 1;
        end else if (m_ph != 7) begin
            hold = (wait_lock_en_i && eff(int'(sel_lock_i)) == m_ph && !lk) ||
                   (wait_match_en_i && eff(int'(sel_match_i)) == m_ph && !mt);
            if (!hold) m_ph = m_ph + 1;
        end
        if (m_ph == eff(int'(sel_gwe_i)))  m_gwe  = 1;
        if (m_ph == eff(int'(sel_gts_i)))  m_gts  = 0;
        if (m_ph == eff(int'(sel_done_i))) m_done = 1;
        m_eos = (m_ph == 7);
        push_exp(tag);
    endtask

    // monitor: pops expected items just after each active edge
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (int'(phase_o) != e.ph) begin
                errors++;
                $display("FAIL %s phase actual=%0d expected=%0d", e.tag, phase_o, e.ph);
            end
            if (gwe_o != e.gwe) begin
                errors++;
                $display("FAIL %s gwe actual=%0b expected=%0b", e.tag, gwe_o, e.gwe);
            end
            if (gts_o != e.gts) begin
                errors++;
                $display("FAIL %s gts actual=%0b expected=%0b", e.tag, gts_o, e.gts);
            end
            if (done_o != e.done) begin
                errors++;
                $display("FAIL %s done actual=%0b expected=%0b", e.tag, done_o, e.done);
            end
            if (eos_o != e.eos) begin
                errors++;
                $display("FAIL %s eos actual=%0b expected=%0b", e.tag, eos_o, e.eos);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Scenario A: R2 gating, R3 stepping, R5 distinct phases, R9 end
        reset_cycle();
        sel_gwe_i = 3'd2; sel_gts_i = 3'd3; sel_done_i = 3'd4;
        wait_lock_en_i = 1'b0; wait_match_en_i = 1'b0;
        reset_cycle();
        cyc(0, 0, 0, 0, "R2");
        cyc(1, 0, 0, 0, "R2");          // start without loaded: ignored
        cyc(0, 1, 0, 0, "R2");          // loaded without start
        cyc(1, 1, 0, 0, "R2 R3");       // start accepted
        for (int i = 0; i < 10; i++) cyc(i % 2 == 0, 1, 0, 0, "R3 R5 R9");

        // Scenario B: R4 clamp, several events in one phase
        reset_cycle();
        sel_gwe_i = 3'd0; sel_gts_i = 3'd7; sel_done_i = 3'd1;
        reset_cycle();
        cyc(1, 1, 0, 0, "R4 R5");
        for (int i = 0; i < 9; i++) cyc(0, 1, 0, 0, "R4 R5 R9");

        // Scenario C: R7 and R8 holds in the phase where gwe fires
        reset_cycle();
        sel_gwe_i = 3'd3; sel_gts_i = 3'd4; sel_done_i = 3'd5;
        sel_lock_i = 3'd3; sel_match_i = 3'd3;
        wait_lock_en_i = 1'b1; wait_match_en_i = 1'b1;
        reset_cycle();
        cyc(1, 1, 0, 0, "R7 R8");
        for (int i = 0; i < 16; i++) cyc(0, 1, i >= 5, i >= 8, "R7 R8 R5");

        // Scenario D: R7 hold clamped to 6, R6 persistence after status drops
        reset_cycle();
        sel_gwe_i = 3'd1; sel_gts_i = 3'd2; sel_done_i = 3'd6;
        sel_lock_i = 3'd7; sel_match_i = 3'd2;
        wait_lock_en_i = 1'b1; wait_match_en_i = 1'b1;
        reset_cycle();
        cyc(1, 1, 0, 1, "R4 R7");
        for (int i = 0; i < 10; i++) cyc(0, 1, i >= 7, 1, "R4 R7");
        for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, "R6 R9");
        reset_cycle();
        cyc(0, 0, 0, 0, "R1");

        @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule